// File: doc/BRIEF.md
# Read-Sequence Save/Restore Command Detector

This block watches the read accesses made to a small memory and picks out a hidden command: six reads in a row from a fixed set of addresses. The last address decides whether the command asks for the volatile contents to be saved to nonvolatile storage or reloaded from it. On success it raises a one-cycle request toward the transfer controller. Commands are carried by ordinary read cycles, so a host that only knows how to read and write the memory can still trigger them.

Chip enable is sampled on the system clock. One access is one continuous low pulse of chip enable. The address is captured in the first low cycle. The access is classed as a write if write enable was low in any cycle of the pulse. It is judged when chip enable returns high. A write or an out-of-order read throws away any partial progress. While the supply is flagged low, save commands are refused. While the transfer controller reports busy, nothing is tracked.

Top module: `unlock_seq_detector`

## Requirements
- R1: Six consecutive reads from hex 000, 555, 2AA, 7FF, 0F0, 70F raise `storeReq`. It goes high in the cycle after the clock edge that first samples `ceN` high at the end of the sixth access.
- R2: The same five leading addresses followed by a read of 70E raise `recallReq`, with the same timing.
- R3: A read of any address other than the next one expected aborts the sequence, and later correct steps alone do not complete it.
- R4: An access during which `weN` was low in any cycle while `ceN` was low is a write. A write aborts the sequence, whatever its address.
- R5: A read of 000 that aborts a sequence counts as the first step of a new one.
- R6: A sixth address of 39C, or any other sixth address besides 70F and 70E, produces no request.
- R7: If `lowSupply` is high when the sixth access completes, a save sequence gives no request. A restore sequence still gives `recallReq`.
- R8: While `busy` is high, no request is raised and any partial progress is discarded.
- R9: One continuous low pulse of `ceN` counts as exactly one step, however many cycles it lasts.
- R10: `storeReq` and `recallReq` are low after reset, last one cycle each, and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | 11 | Memory address of the current access |
| ceN | input | 1 | Active-low chip enable; one low pulse is one access |
| weN | input | 1 | Active-low write enable |
| lowSupply | input | 1 | High when the supply is below the save threshold |
| busy | input | 1 | High while the transfer controller is working |
| storeReq | output | 1 | One-cycle save request |
| recallReq | output | 1 | One-cycle restore request |

## Verification
The hardest case to reach from the ports is an abort that must also restart the sequence. A stray read of 000 in the middle of a sequence has to be rejected as the wrong step and also accepted as step one, and only a later full tail reveals which of these happened. The stimulus builds that case on purpose. It also covers a write whose `weN` falls only in the second cycle of the chip-enable pulse. Finally, it raises `busy` between the third and fourth steps and checks that the rest of the sequence, given on its own, stays silent.

// File: rtl/unlock_seq_pkg.sv
package unlock_seq_pkg;

  // Access summary produced by the datapath when chip enable returns high.
  typedef struct packed {
    logic valid;
    logic isWrite;
    logic isStore;
    logic isRecall;
  } accEvt_t;

  // Strobes from the control back to the datapath output registers.
  typedef struct packed {
    logic fireStore;
    logic fireRecall;
  } cmdStrobe_t;

endpackage

// File: rtl/unlock_seq_datapath.sv
module unlock_seq_datapath
  import unlock_seq_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PREFIX_LEN = 5,
  parameter logic [PREFIX_LEN*ADDR_W-1:0] PREFIX_KEYS = '0,
  parameter logic [ADDR_W-1:0] STORE_ADDR = '0,
  parameter logic [ADDR_W-1:0] RECALL_ADDR = '0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  ceN,
  input  logic                  weN,
  input  cmdStrobe_t            strobe,
  output accEvt_t               evt,
  output logic [PREFIX_LEN-1:0] keyHit,
  output logic                  storeReq,
  output logic                  recallReq
);

  logic              ceQ;
  logic [ADDR_W-1:0] addrQ;
  logic              wrSeen;
  logic              ceFall;
  logic              ceRise;

  assign ceFall = ceQ & ~ceN;
  assign ceRise = ~ceQ & ceN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceQ       <= 1'b1;
      addrQ     <= '0;
      wrSeen    <= 1'b0;
      storeReq  <= 1'b0;
      recallReq <= 1'b0;
    end else begin
      ceQ <= ceN;
      if (ceFall) begin
        addrQ  <= addr;
        wrSeen <= ~weN;
      end else if (!ceN) begin
        wrSeen <= wrSeen | ~weN;
      end
      storeReq  <= strobe.fireStore;
      recallReq <= strobe.fireRecall;
    end
  end

  for (genvar g = 0; g < PREFIX_LEN; g++) begin : g_key
    assign keyHit[g] = (addrQ == PREFIX_KEYS[g*ADDR_W +: ADDR_W]);
  end

  always_comb begin
    evt.valid    = ceRise;
    evt.isWrite  = wrSeen;
    evt.isStore  = (addrQ == STORE_ADDR);
    evt.isRecall = (addrQ == RECALL_ADDR);
  end

endmodule

// File: rtl/unlock_seq_ctrl.sv
module unlock_seq_ctrl
  import unlock_seq_pkg::*;
#(
  parameter int PREFIX_LEN = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  accEvt_t               evt,
  input  logic [PREFIX_LEN-1:0] keyHit,
  input  logic                  lowSupply,
  input  logic                  busy,
  output cmdStrobe_t            strobe
);

  localparam int STEP_W = $clog2(PREFIX_LEN + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PREFIX_LEN);
  localparam logic [STEP_W-1:0] ONE = STEP_W'(1);

  logic [STEP_W-1:0]   stepQ;
  logic [STEP_W-1:0]   stepD;
  logic [STEP_W-1:0]   restartStep;
  logic [PREFIX_LEN:0] hitExt;

  assign hitExt      = {1'b0, keyHit};
  assign restartStep = keyHit[0] ? ONE : '0;

  always_comb begin
    stepD  = stepQ;
    strobe = '0;
    if (busy) begin
      stepD = '0;
    end else if (evt.valid) begin
      if (evt.isWrite) begin
        stepD = '0;
      end else if (stepQ == LAST_STEP) begin
        if (evt.isStore) begin
          strobe.fireStore = ~lowSupply;
          stepD = '0;
        end else if (evt.isRecall) begin
          strobe.fireRecall = 1'b1;
          stepD = '0;
        end else begin
          stepD = restartStep;
        end
      end else if (hitExt[stepQ]) begin
        stepD = stepQ + ONE;
      end else begin
        stepD = restartStep;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stepQ <= '0;
    else       stepQ <= stepD;
  end

endmodule

// File: rtl/unlock_seq_detector.sv
module unlock_seq_detector
  import unlock_seq_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PREFIX_LEN = 5,
  parameter logic [PREFIX_LEN*ADDR_W-1:0] PREFIX_KEYS =
    {11'h0F0, 11'h7FF, 11'h2AA, 11'h555, 11'h000},
  parameter logic [ADDR_W-1:0] STORE_ADDR = 11'h70F,
  parameter logic [ADDR_W-1:0] RECALL_ADDR = 11'h70E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ceN,
  input  logic              weN,
  input  logic              lowSupply,
  input  logic              busy,
  output logic              storeReq,
  output logic              recallReq
);

  accEvt_t               evt;
  cmdStrobe_t            strobe;
  logic [PREFIX_LEN-1:0] keyHit;

  unlock_seq_datapath #(
    .ADDR_W(ADDR_W), .PREFIX_LEN(PREFIX_LEN), .PREFIX_KEYS(PREFIX_KEYS),
    .STORE_ADDR(STORE_ADDR), .RECALL_ADDR(RECALL_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .ceN(ceN), .weN(weN),
    .strobe(strobe), .evt(evt), .keyHit(keyHit),
    .storeReq(storeReq), .recallReq(recallReq)
  );

  unlock_seq_ctrl #(.PREFIX_LEN(PREFIX_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt), .keyHit(keyHit),
    .lowSupply(lowSupply), .busy(busy), .strobe(strobe)
  );

endmodule

// File: rtl/unlock_seq_checker.sv
module unlock_seq_checker (
  input logic clk,
  input logic rstN,
  input logic ceN,
  input logic lowSupply,
  input logic busy,
  input logic storeReq,
  input logic recallReq
);

  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(storeReq && recallReq));

  p_store_one_cycle_r10: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |=> !storeReq);

  p_recall_one_cycle_r10: assert property (@(posedge clk) disable iff (!rstN)
    recallReq |=> !recallReq);

  p_store_supply_ok_r7: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |-> !$past(lowSupply));

  p_not_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (storeReq || recallReq) |-> !$past(busy));

  // R9: a request follows only the cycle in which chip enable went back high
  p_after_ce_rise_r9: assert property (@(posedge clk) disable iff (!rstN)
    (storeReq || recallReq) |-> ($past(ceN) && !$past(ceN, 2)));

endmodule

bind unlock_seq_detector unlock_seq_checker u_chk (.*);

// File: tb/unlock_seq_detector_bench.sv
module unlock_seq_detector_bench;

  typedef struct {
    logic [1:0] exp;
    string      tag;
  } sbItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [10:0] addr = '0;
  logic        ceN = 1'b1;
  logic        weN = 1'b1;
  logic        lowSupply = 1'b0;
  logic        busy = 1'b0;
  logic        storeReq;
  logic        recallReq;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  sbItem_t sbQ[$];
  event sampleEv;

  always #2 clk = ~clk;

  unlock_seq_detector u_unlock_seq_detector (
    .clk(clk), .rstN(rstN), .addr(addr), .ceN(ceN), .weN(weN),
    .lowSupply(lowSupply), .busy(busy),
    .storeReq(storeReq), .recallReq(recallReq)
  );

  // Monitor: pops one expectation per sample point and compares.
  initial begin
    forever begin
      sbItem_t it;
      @(sampleEv);
      it = sbQ.pop_front();
      checks++;
      if ({storeReq, recallReq} !== it.exp) begin
        fails++;
        $display("FAIL %s: got {store,recall}=%b expected %b",
                 it.tag, {storeReq, recallReq}, it.exp);
      end
    end
  end

  task automatic expectNow(input logic [1:0] e, input string tag);
    sbQ.push_back('{exp: e, tag: tag});
    ->sampleEv;
    #0;
  endtask

  // One chip-enable pulse of lowCycles cycles; a write drops weN from
  // the second low cycle. Result sampled after the closing edge, then
  // one cycle later to confirm the pulse is gone.
  task automatic access(input logic [10:0] a, input bit wr, input int lowCycles,
                        input logic [1:0] e, input string tag);
    @(negedge clk);
    addr = a; ceN = 1'b0; weN = 1'b1;
    for (int i = 0; i < lowCycles; i++) begin
      @(negedge clk);
      if (wr && i == 0) weN = 1'b0;
    end
    ceN = 1'b1; weN = 1'b1;
    @(negedge clk);
    expectNow(e, tag);
    @(negedge clk);
    expectNow(2'b00, {tag, " pulse ended R10"});
  endtask

  task automatic rd(input logic [10:0] a, input logic [1:0] e, input string tag);
    access(a, 1'b0, 1, e, tag);
  endtask

  task automatic prefix(input string tag);
    rd(11'h000, 2'b00, tag);
    rd(11'h555, 2'b00, tag);
    rd(11'h2AA, 2'b00, tag);
    rd(11'h7FF, 2'b00, tag);
    rd(11'h0F0, 2'b00, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expectNow(2'b00, "R10 reset state");

    // R1 save sequence
    prefix("R1 prefix");
    rd(11'h70F, 2'b10, "R1 store");

    // R2 restore sequence
    prefix("R2 prefix");
    rd(11'h70E, 2'b01, "R2 recall");

    // R3 stray read mid-sequence, then the remaining tail alone
    rd(11'h000, 2'b00, "R3"); rd(11'h555, 2'b00, "R3");
    rd(11'h123, 2'b00, "R3 stray");
    rd(11'h2AA, 2'b00, "R3"); rd(11'h7FF, 2'b00, "R3");
    rd(11'h0F0, 2'b00, "R3"); rd(11'h70F, 2'b00, "R3 no store after abort");

    // R4 write to the expected address aborts
    rd(11'h000, 2'b00, "R4"); rd(11'h555, 2'b00, "R4");
    access(11'h2AA, 1'b1, 3, 2'b00, "R4 write");
    rd(11'h7FF, 2'b00, "R4"); rd(11'h0F0, 2'b00, "R4");
    rd(11'h70E, 2'b00, "R4 no recall after write");

    // R5 aborting read of 000 restarts at step two
    rd(11'h000, 2'b00, "R5"); rd(11'h555, 2'b00, "R5"); rd(11'h2AA, 2'b00, "R5");
    rd(11'h000, 2'b00, "R5 abort on 000");
    rd(11'h555, 2'b00, "R5"); rd(11'h2AA, 2'b00, "R5"); rd(11'h7FF, 2'b00, "R5");
    rd(11'h0F0, 2'b00, "R5"); rd(11'h70F, 2'b10, "R5 store after restart");

    // R6 reserved and arbitrary final addresses
    prefix("R6 prefix");
    rd(11'h39C, 2'b00, "R6 reserved 39C");
    prefix("R6 prefix");
    rd(11'h70D, 2'b00, "R6 other final");

    // R7 low supply blocks saves only
    lowSupply = 1'b1;
    prefix("R7 prefix");
    rd(11'h70F, 2'b00, "R7 store blocked");
    prefix("R7 prefix");
    rd(11'h70E, 2'b01, "R7 recall allowed");
    lowSupply = 1'b0;

    // R8 busy
    busy = 1'b1;
    prefix("R8 prefix busy");
    rd(11'h70F, 2'b00, "R8 store while busy");
    busy = 1'b0;
    rd(11'h000, 2'b00, "R8"); rd(11'h555, 2'b00, "R8"); rd(11'h2AA, 2'b00, "R8");
    @(negedge clk); busy = 1'b1;
    repeat (2) @(negedge clk); busy = 1'b0;
    rd(11'h7FF, 2'b00, "R8"); rd(11'h0F0, 2'b00, "R8");
    rd(11'h70F, 2'b00, "R8 progress discarded");
    prefix("R8 recovery");
    rd(11'h70F, 2'b10, "R8 store after busy");

    // R9 long pulses count once; a repeated pulse is a second step
    access(11'h000, 1'b0, 9, 2'b00, "R9 long");
    access(11'h555, 1'b0, 5, 2'b00, "R9 long");
    rd(11'h2AA, 2'b00, "R9"); rd(11'h7FF, 2'b00, "R9"); rd(11'h0F0, 2'b00, "R9");
    access(11'h70E, 1'b0, 7, 2'b01, "R9 recall via long pulses");
    rd(11'h000, 2'b00, "R9"); rd(11'h555, 2'b00, "R9");
    rd(11'h555, 2'b00, "R9 repeated pulse");
    rd(11'h2AA, 2'b00, "R9"); rd(11'h7FF, 2'b00, "R9"); rd(11'h0F0, 2'b00, "R9");
    rd(11'h70F, 2'b00, "R9 repeat aborted");

    repeat (2) @(negedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule